// File: doc/BRIEF.md
# Floating-Point Environment Store Sequencer

This block saves a floating-point unit's environment (its control, status and tag words) to memory when a store-environment command arrives. The command carries a base byte address, an operand-size flag that picks a compact or a wide image, and a flag that picks whether the store waits on unmasked pending exceptions. The three words are taken from the unit at the moment the command is accepted. They then go out one 16-bit halfword per beat over a valid/ready write port, and the rest of the image is padded with zeros where the error-pointer information lives.

When the last beat has been accepted, the block offers the unit a new control word in a one-cycle update. This word is the saved control word with every exception mask bit forced to one, so that a handler entered afterwards cannot be interrupted by further floating-point faults. The waiting variant first compares the status exception bits with the control mask bits. If any exception is pending and unmasked, it raises an error request and writes nothing until an error-clear pulse arrives. The no-wait variant skips this comparison.

The controller has four states. `ST_IDLE` accepts a command. `ST_ERR_HOLD` holds the error request. `ST_EMIT` drives write beats. `ST_MASK` issues the control-word update. Its transitions are:

- IDLE→EMIT on a command that needs no hold.
- IDLE→ERR_HOLD on a waiting command that finds an unmasked pending exception.
- ERR_HOLD→EMIT on the error-clear pulse.
- EMIT→MASK when the last beat is accepted.
- MASK→IDLE after one cycle.

Top module: `fenv_store_seq`

## Requirements
- R1: A command is accepted only in a cycle where `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance up to and including the control-update cycle. `cmd_valid` raised while `busy` is high has no effect: it causes no extra write beats.
- R2: With `cmd_wide`=0 the block makes exactly 7 beats, at byte addresses base+0, base+2, …, base+12. The data of these beats is control word, status word, tag word, then four zero halfwords.
- R3: With `cmd_wide`=1 the block makes exactly 14 beats, at byte addresses base+0 to base+26 in steps of 2. The data of these beats is control word, 0, status word, 0, tag word, 0, then eight zero halfwords.
- R4: A command with `cmd_wait`=1 finds an exception pending and unmasked when, for some i in 5..0, `sw_in[i]`=1 and `cw_in[i]`=0. Such a command raises `err_req` and drives no beat until `err_clr` is pulsed. After the pulse, `err_req` falls and the normal write sequence follows.
- R5: A waiting command with no unmasked pending exception writes at once and keeps `err_req` low; a pending exception whose mask bit is set does not count. A command with `cmd_wait`=0 never raises `err_req`, whatever the status word holds.
- R6: In the cycle after the last beat is accepted, `cw_upd_valid` is high for exactly one cycle. In that cycle `cw_upd_word` equals the saved control word with bits 5:0 set to 1 and bits 15:6 unchanged. Beat 0 carries the control word before masking.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R8: During and right after reset, `busy`, `err_req`, `mem_valid` and `cw_upd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Store-environment command strobe |
| cmd_wait | input | 1 | 1 = check for unmasked pending exceptions first |
| cmd_wide | input | 1 | 1 = 32-bit operand size (28-byte image), 0 = 16-bit (14-byte image) |
| cmd_base | input | ADDR_W | Byte address of the image |
| cw_in | input | 16 | Current control word |
| sw_in | input | 16 | Current status word |
| tw_in | input | 16 | Current tag word |
| err_clr | input | 1 | Pulse that releases a held error request |
| mem_ready | input | 1 | Memory accepts the current beat |
| busy | output | 1 | Command in progress |
| err_req | output | 1 | Unmasked pending exception blocks the store |
| mem_valid | output | 1 | Write beat valid |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 16 | Halfword of the beat |
| cw_upd_valid | output | 1 | Control-word update strobe |
| cw_upd_word | output | 16 | Control word with all exception masks set |

## Verification
The store is tried in both image sizes, with both the waiting and the no-wait variant. Status words are chosen so that the variants can be told apart: one has no pending bits, one has pending bits that are all masked, and one has a pending bit whose mask is clear; only the last, with the waiting flag set, must hold the writes back. The control words keep some mask bits clear, which shows both that beat 0 carries the unmasked value and that the update ORs in only the low six bits. A random ready pattern stretches beats to test data holding, a command raised in mid-transfer must leave no trace, and a base address near the top of the address space checks that the address steps stay correct.

// File: rtl/fenv_pkg.sv
package fenv_pkg;

    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ERR_HOLD = 2'd1,
        ST_EMIT     = 2'd2,
        ST_MASK     = 2'd3
    } fenv_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] ctrl;
        logic [HALF_W-1:0] stat;
        logic [HALF_W-1:0] tag;
    } fenv_words_t;

endpackage

// File: rtl/fenv_pend_chk.sv
module fenv_pend_chk #(
    parameter int MASK_W = 6
) (
    input  logic [fenv_pkg::HALF_W-1:0] ctrl,
    input  logic [fenv_pkg::HALF_W-1:0] stat,
    output logic                        pend
);

    logic [MASK_W-1:0] open_bits;

    // An exception counts only if its flag is raised and its mask is clear
    for (genvar g = 0; g < MASK_W; g++) begin : g_bit
        assign open_bits[g] = stat[g] & ~ctrl[g];
    end

    assign pend = |open_bits;

endmodule

// File: rtl/fenv_slot_gen.sv
module fenv_slot_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0]           base,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        wide,
    input  fenv_pkg::fenv_words_t       words,
    output logic [ADDR_W-1:0]           addr,
    output logic [fenv_pkg::HALF_W-1:0] data
);

    // Slot positions in halfwords for each image size
    localparam int NARROW_STEP = 1;
    localparam int WIDE_STEP   = 2;

    logic [IDX_W-1:0] step;

    assign step = wide ? IDX_W'(WIDE_STEP) : IDX_W'(NARROW_STEP);
    assign addr = base + ADDR_W'({idx, 1'b0});

    always_comb begin
        data = '0;
        if (idx == '0) begin
            data = words.ctrl;
        end else if (idx == step) begin
            data = words.stat;
        end else if (idx == IDX_W'(2 * step)) begin
            data = words.tag;
        end
    end

endmodule

// File: rtl/fenv_ctrl_fsm.sv
module fenv_ctrl_fsm #(
    parameter int NARROW_BEATS = 7,
    parameter int WIDE_BEATS   = 14,
    parameter int IDX_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_wait,
    input  logic             pend,
    input  logic             wide_q,
    input  logic             err_clr,
    input  logic             mem_ready,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             err_req,
    output logic             mem_valid,
    output logic             upd_valid
);
    import fenv_pkg::*;

    localparam logic [IDX_W-1:0] LAST_N = IDX_W'(NARROW_BEATS - 1);
    localparam logic [IDX_W-1:0] LAST_W = IDX_W'(WIDE_BEATS - 1);

    fenv_state_e state_q, state_d;
    logic        fire;
    logic        last;

    assign fire = (state_q == ST_EMIT) && mem_ready;
    assign last = idx == (wide_q ? LAST_W : LAST_N);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (accept) begin
            idx <= '0;
        end else if (fire) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = (cmd_wait && pend) ? ST_ERR_HOLD : ST_EMIT;
                end
            end
            ST_ERR_HOLD: begin
                if (err_clr) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (fire && last) begin
                    state_d = ST_MASK;
                end
            end
            ST_MASK: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept    = 1'b0;
        busy      = 1'b1;
        err_req   = 1'b0;
        mem_valid = 1'b0;
        upd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = cmd_valid;
            end
            ST_ERR_HOLD: err_req   = 1'b1;
            ST_EMIT:     mem_valid = 1'b1;
            ST_MASK:     upd_valid = 1'b1;
            default:     busy      = 1'b0;
        endcase
    end

endmodule

// File: rtl/fenv_store_seq.sv
module fenv_store_seq #(
    parameter int ADDR_W       = 32,
    parameter int MASK_W       = 6,
    parameter int NARROW_BEATS = 7,
    parameter int WIDE_BEATS   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_wait,
    input  logic              cmd_wide,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [15:0]       cw_in,
    input  logic [15:0]       sw_in,
    input  logic [15:0]       tw_in,
    input  logic              err_clr,
    input  logic              mem_ready,
    output logic              busy,
    output logic              err_req,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_data,
    output logic              cw_upd_valid,
    output logic [15:0]       cw_upd_word
);
    import fenv_pkg::*;

    localparam int IDX_W = $clog2(WIDE_BEATS);

    fenv_words_t       words_q;
    logic [ADDR_W-1:0] base_q;
    logic              wide_q;
    logic              accept;
    logic              pend;
    logic [IDX_W-1:0]  idx;

    // Snapshot of the command and the unit's words at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            base_q  <= '0;
            wide_q  <= 1'b0;
        end else if (accept) begin
            words_q <= '{ctrl: cw_in, stat: sw_in, tag: tw_in};
            base_q  <= cmd_base;
            wide_q  <= cmd_wide;
        end
    end

    fenv_pend_chk #(.MASK_W(MASK_W)) u_pend (
        .ctrl (cw_in),
        .stat (sw_in),
        .pend (pend)
    );

    fenv_ctrl_fsm #(
        .NARROW_BEATS (NARROW_BEATS),
        .WIDE_BEATS   (WIDE_BEATS),
        .IDX_W        (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_wait  (cmd_wait),
        .pend      (pend),
        .wide_q    (wide_q),
        .err_clr   (err_clr),
        .mem_ready (mem_ready),
        .accept    (accept),
        .idx       (idx),
        .busy      (busy),
        .err_req   (err_req),
        .mem_valid (mem_valid),
        .upd_valid (cw_upd_valid)
    );

    fenv_slot_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_slot (
        .base  (base_q),
        .idx   (idx),
        .wide  (wide_q),
        .words (words_q),
        .addr  (mem_addr),
        .data  (mem_data)
    );

    assign cw_upd_word = {words_q.ctrl[HALF_W-1:MASK_W],
                          words_q.ctrl[MASK_W-1:0] | {MASK_W{1'b1}}};

endmodule

// File: rtl/fenv_store_sva.sv
module fenv_store_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              err_req,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_data,
    input logic              cw_upd_valid,
    input logic [15:0]       cw_upd_word
);

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(2))); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_req |-> !mem_valid); // R4

    AST_UPD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cw_upd_valid |-> (&cw_upd_word[5:0]) && !mem_valid); // R6

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cw_upd_valid |=> !cw_upd_valid && !busy); // R1

    AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || err_req || cw_upd_valid) |-> busy); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !busy && !mem_valid && !err_req && !cw_upd_valid); // R8

endmodule

bind fenv_store_seq fenv_store_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .err_req      (err_req),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .cw_upd_valid (cw_upd_valid),
    .cw_upd_word  (cw_upd_word)
);

// File: tb/fenv_store_seq_tb.sv
module fenv_store_seq_tb;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_wait = 1'b0;
    logic              cmd_wide = 1'b0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [15:0]       cw_in = '0;
    logic [15:0]       sw_in = '0;
    logic [15:0]       tw_in = '0;
    logic              err_clr = 1'b0;
    logic              mem_ready;
    logic              busy;
    logic              err_req;
    logic              mem_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_data;
    logic              cw_upd_valid;
    logic [15:0]       cw_upd_word;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  n_beats = 0;
    bit  done    = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [ADDR_W-1:0] exp_addr_q[$];
    logic [15:0]       exp_data_q[$];
    logic [15:0]       exp_upd_q[$];

    always #2.5 clk = ~clk;

    fenv_store_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wait(cmd_wait),
        .cmd_wide(cmd_wide), .cmd_base(cmd_base), .cw_in(cw_in), .sw_in(sw_in),
        .tw_in(tw_in), .err_clr(err_clr), .mem_ready(mem_ready), .busy(busy),
        .err_req(err_req), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .cw_upd_valid(cw_upd_valid), .cw_upd_word(cw_upd_word)
    );

    // Memory back-pressure pattern, changed just after each edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    assign mem_ready = lfsr[0] | lfsr[3];

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Monitor: compares beats and control updates with the scoreboard
    logic              held = 1'b0;
    logic [ADDR_W-1:0] held_addr;
    logic [15:0]       held_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check(mem_valid && mem_addr == held_addr && mem_data == held_data,
                      "R7 beat held under back-pressure", mem_addr, held_addr);
            end
            held = mem_valid && !mem_ready;
            held_addr = mem_addr;
            held_data = mem_data;
            if (mem_valid && mem_ready) begin
                n_beats++;
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R1 unexpected beat (R2/R3)", mem_addr, '0);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    logic [15:0]       ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    check(mem_addr == ea, "R2/R3 beat address", mem_addr, ea);
                    check(mem_data == ed, "R2/R3 beat data", {16'h0, mem_data}, {16'h0, ed});
                end
            end
            if (cw_upd_valid) begin
                if (exp_upd_q.size() == 0) begin
                    check(1'b0, "R6 unexpected control update", {16'h0, cw_upd_word}, '0);
                end else begin
                    logic [15:0] eu;
                    eu = exp_upd_q.pop_front();
                    check(exp_addr_q.size() == 0, "R6 update after last beat",
                          exp_addr_q.size(), 0);
                    check(cw_upd_word == eu, "R6 masked control word",
                          {16'h0, cw_upd_word}, {16'h0, eu});
                end
            end
        end
    end

    // Driver: pushes expected results and runs one command to completion
    task automatic run_cmd(input bit w, input bit wide, input logic [ADDR_W-1:0] base,
                           input logic [15:0] cw, input logic [15:0] sw,
                           input logic [15:0] tw, input bit exp_err, input bit inject);
        int n;
        int beats0;
        n = wide ? 14 : 7;
        for (int i = 0; i < n; i++) begin
            logic [15:0] d;
            d = 16'h0;
            if (i == 0) d = cw;
            else if (i == (wide ? 2 : 1)) d = sw;
            else if (i == (wide ? 4 : 2)) d = tw;
            exp_addr_q.push_back(base + ADDR_W'(2 * i));
            exp_data_q.push_back(d);
        end
        exp_upd_q.push_back({cw[15:6], 6'h3F});
        @(negedge clk);
        cmd_wait = w; cmd_wide = wide; cmd_base = base;
        cw_in = cw; sw_in = sw; tw_in = tw;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R1 busy after acceptance", busy, 1);
        check(err_req == exp_err, exp_err ? "R4 error request raised" :
              "R5 no error request", err_req, exp_err);
        if (exp_err) begin
            beats0 = n_beats;
            repeat (6) @(negedge clk);
            check(err_req == 1'b1 && n_beats == beats0 && !mem_valid,
                  "R4 no beats while held", n_beats - beats0, 0);
            err_clr = 1'b1;
            @(negedge clk);
            err_clr = 1'b0;
            check(err_req == 1'b0, "R4 error request released", err_req, 0);
        end
        if (inject) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_base = base + 32'h400; cmd_wide = 1'b1;
            @(negedge clk);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        check(exp_addr_q.size() == 0 && exp_upd_q.size() == 0,
              wide ? "R3 all beats and update seen" : "R2 all beats and update seen",
              exp_addr_q.size(), 0);
        @(negedge clk);
        check(!busy && !mem_valid, "R1 idle after command", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !mem_valid && !err_req && !cw_upd_valid,
              "R8 outputs low in reset", {busy, mem_valid, err_req, cw_upd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_valid && !err_req && !cw_upd_valid,
              "R8 outputs low after reset", {busy, mem_valid, err_req, cw_upd_valid}, 0);

        // R5: no-wait ignores an unmasked pending exception
        run_cmd(1'b0, 1'b0, 32'h0000_0100, 16'h1240, 16'h0001, 16'hFFF0, 1'b0, 1'b0);
        // R3: wide image, no wait
        run_cmd(1'b0, 1'b1, 32'h0000_1000, 16'h0372, 16'h3800, 16'h5A5A, 1'b0, 1'b0);
        // R4: waiting, narrow, bit 2 pending and unmasked
        run_cmd(1'b1, 1'b0, 32'h0000_2002, 16'h037B, 16'h0004, 16'h00FF, 1'b1, 1'b0);
        // R5: waiting, wide, pending bits all masked
        run_cmd(1'b1, 1'b1, 32'h0000_3000, 16'h0F3F, 16'h003F, 16'hAAAA, 1'b0, 1'b0);
        // R4: waiting, wide, bit 5 pending and unmasked
        run_cmd(1'b1, 1'b1, 32'h0000_4010, 16'h801F, 16'h0020, 16'h1234, 1'b1, 1'b0);
        // R1: command raised during a transfer is ignored
        run_cmd(1'b0, 1'b0, 32'h0000_5000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1);
        // R2: narrow image near the top of the address space, waiting, clean status
        run_cmd(1'b1, 1'b0, 32'hFFFF_FFF0, 16'hC0C0, 16'h4000, 16'h0F0F, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule